// File: doc/BRIEF.md
# Dual-Core Package Halt-State Controller

This block tracks the idle state of each of two processor cores and of the package they share. A core halts when it reports that it executed a halt or monitor-wait instruction. A halted core wakes on any of six event sources: a system-management interrupt, a bus initialisation error, an init request, a non-maskable interrupt, a maskable interrupt, or an interrupt that arrives over the system bus. While a core is halted, a stop-clock request parks it in a stop-grant condition. When the request is withdrawn, the core goes back to halt, not to run.

When every core is halted and the enhanced-halt enable is set, the package moves to a low-voltage state in two steps. It first asks the clock-ratio unit for a lower core ratio and waits for the acknowledge. Only then does it ask the voltage unit for a lower voltage ID. It leaves the low-voltage state in the opposite order: voltage back up first, then the ratio. The woken core is released only after both steps are complete. A wake that arrives part way through the entry steps cancels the entry, and the steps already taken are undone in reverse order. The bus clock is never touched. Only the core-ratio request changes. Snoops are granted in the settled states and held off while a ratio or voltage change is under way.

Core states are RUN, HALT and STOPGRANT. Core transitions: RUN→HALT (halt request, or return from a management handler with return-to-halt set), HALT→STOPGRANT (stop-clock asserted), STOPGRANT→HALT (stop-clock released), HALT→RUN (wake pending and package settled). Package states are NORMAL, HALT, ENTER_RATIO, ENTER_VID, EXT_HALT, EXIT_VID and EXIT_RATIO. Package transitions: NORMAL↔HALT (some core running or none running), NORMAL/HALT→ENTER_RATIO (entry), ENTER_RATIO→ENTER_VID (ratio acknowledged), ENTER_VID→EXT_HALT (voltage acknowledged), ENTER_RATIO→EXIT_RATIO and ENTER_VID→EXIT_VID (abort), EXT_HALT→EXIT_VID (wake), EXIT_VID→EXIT_RATIO (voltage restored), EXIT_RATIO→HALT (ratio restored).

Top module: `dual_core_idle_ctrl`

## Requirements
- R1: A one-cycle `halt_req[i]` pulse on a running core, with no wake event for that core in the same cycle, puts that core in HALT at the next clock edge. The other core's state is unchanged.
- R2: An event on any one of `smi_evt`, `binit_evt`, `init_evt`, `nmi_evt`, `intr_evt` or `bus_int_evt` for a halted core, while the package is in NORMAL or HALT, makes that core RUN two clock edges after the event is sampled.
- R3: When `rst_n` goes low, every output returns at once, without waiting for a clock edge, to: all cores RUN, package NORMAL, `ratio_low_req`=0, `vid_low_req`=0, `snoop_gnt`=0. This holds even in the middle of an entry or exit sequence.
- R4: If `stop_clk_req` is high at an edge while a core is in HALT, the core moves to STOPGRANT. When `stop_clk_req` is low at a later edge, the core moves from STOPGRANT to HALT and never directly to RUN.
- R5: `snoop_gnt` is high one cycle after `snoop_req` is sampled high while the package is in NORMAL, HALT or EXT_HALT. It is low after a request sampled in ENTER_RATIO, ENTER_VID, EXIT_VID or EXIT_RATIO.
- R6: The package goes to HALT when no core is RUN and entry to the low-voltage sequence is not allowed. It returns to NORMAL once any core is RUN.
- R7: The package leaves NORMAL or HALT for ENTER_RATIO only when every core is in HALT, `deep_en`=1 and no wake is pending. With `deep_en`=0 it stays in HALT and `ratio_low_req` stays 0.
- R8: During entry, `ratio_low_req` rises in ENTER_RATIO with `vid_low_req`=0. ENTER_VID, where `vid_low_req` rises, follows only after `ratio_ack`=1. EXT_HALT follows only after `vid_ack`=1.
- R9: A wake in EXT_HALT leads to EXIT_VID, with `vid_low_req`=0 and `ratio_low_req` still 1. After `vid_ack`=0 the package goes to EXIT_RATIO with `ratio_low_req`=0. After `ratio_ack`=0 it goes to HALT. The woken core becomes RUN only after that, and then the package becomes NORMAL.
- R10: A wake pending in ENTER_RATIO aborts to EXIT_RATIO. A wake pending in ENTER_VID aborts to EXIT_VID. The unwinding then proceeds as in R9.
- R11: A core woken by `smi_evt` that receives an `smi_done` pulse goes to HALT when `smi_ret_halt`=1 and stays RUN when `smi_ret_halt`=0. An `smi_done` pulse with no outstanding management interrupt is ignored.
- R12: `pkg_state` encodes NORMAL=0, HALT=1, ENTER_RATIO=2, ENTER_VID=3, EXT_HALT=4, EXIT_VID=5, EXIT_RATIO=6. Each 2-bit field `core_state[2i+1:2i]` encodes RUN=0, HALT=1, STOPGRANT=2. `core_running[i]` is 1 exactly when core i is RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | NCORES | Per-core pulse: halt or monitor-wait executed |
| deep_en | input | 1 | Enhanced package halt enable |
| smi_evt | input | NCORES | Per-core management interrupt event |
| binit_evt | input | NCORES | Per-core bus initialisation error event |
| init_evt | input | NCORES | Per-core init event |
| nmi_evt | input | NCORES | Per-core non-maskable interrupt line event |
| intr_evt | input | NCORES | Per-core maskable interrupt line event |
| bus_int_evt | input | NCORES | Per-core interrupt delivered over the system bus |
| smi_done | input | NCORES | Per-core pulse: management handler returned |
| smi_ret_halt | input | NCORES | Per-core flag: handler returns to halt |
| stop_clk_req | input | 1 | Stop-clock request |
| snoop_req | input | 1 | Snoop request |
| ratio_ack | input | 1 | Clock-ratio unit setting: 1 means low ratio applied |
| vid_ack | input | 1 | Voltage unit setting: 1 means low voltage applied |
| core_running | output | NCORES | Per-core running flag |
| core_state | output | 2*NCORES | Per-core state fields |
| pkg_state | output | 3 | Package state |
| ratio_low_req | output | 1 | Request lower core ratio (level) |
| vid_low_req | output | 1 | Request lower voltage ID (level) |
| snoop_gnt | output | 1 | Snoop service grant |

## Verification
The ordering assertions rely on the clock-ratio and voltage units. Each acknowledge must be a level that changes only toward its current request and never ahead of it. In particular, `vid_ack` must already be low when the ratio request is withdrawn. The bench meets this in two ways. One ack model copies each request with one cycle of delay. In manual mode, the bench sets an acknowledge high only while the matching request is high and leaves it low during unwinding. Event, `halt_req` and `smi_done` inputs are single-cycle pulses driven on the falling clock edge, so every input is stable at the sampling edge.

// File: rtl/idle_ctrl_pkg.sv
package idle_ctrl_pkg;

    localparam int CORE_ST_W = 2;
    localparam int PKG_ST_W  = 3;

    typedef enum logic [CORE_ST_W-1:0] {
        C_RUN       = 2'd0,
        C_HALT      = 2'd1,
        C_STOPGRANT = 2'd2
    } core_st_e;

    typedef enum logic [PKG_ST_W-1:0] {
        P_NORMAL      = 3'd0,
        P_HALT        = 3'd1,
        P_ENTER_RATIO = 3'd2,
        P_ENTER_VID   = 3'd3,
        P_EXT_HALT    = 3'd4,
        P_EXIT_VID    = 3'd5,
        P_EXIT_RATIO  = 3'd6
    } pkg_st_e;

endpackage

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
    import idle_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     halt_req,
    input  logic     wake_evt,
    input  logic     smi_evt,
    input  logic     smi_done,
    input  logic     smi_ret_halt,
    input  logic     stop_clk_req,
    input  logic     pkg_allow,
    output core_st_e state_o,
    output logic     wake_pend_o
);

    core_st_e state_q, state_d;
    logic     pend_q, pend_d;
    logic     smi_act_q, smi_act_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_RUN: begin
                if (!wake_evt && smi_done && smi_act_q && smi_ret_halt)
                    state_d = C_HALT;
                else if (!wake_evt && halt_req)
                    state_d = C_HALT;
            end
            C_HALT: begin
                if (stop_clk_req)
                    state_d = C_STOPGRANT;
                else if (pend_q && pkg_allow)
                    state_d = C_RUN;
            end
            C_STOPGRANT: begin
                if (!stop_clk_req)
                    state_d = C_HALT;
            end
            default: state_d = C_RUN;
        endcase
    end

    // wake is remembered until the core actually resumes
    always_comb begin
        pend_d = (state_q != C_RUN) && (state_d != C_RUN) && (pend_q || wake_evt);
    end

    // outstanding management interrupt bookkeeping for the return path
    always_comb begin
        smi_act_d = smi_act_q;
        if (smi_evt)
            smi_act_d = 1'b1;
        else if (smi_done)
            smi_act_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= C_RUN;
            pend_q    <= 1'b0;
            smi_act_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            pend_q    <= pend_d;
            smi_act_q <= smi_act_d;
        end
    end

    always_comb begin
        state_o     = state_q;
        wake_pend_o = pend_q;
    end

    // stop-grant never resumes execution directly
    assert_stopgrant_to_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_STOPGRANT) |=> (state_q != C_RUN));

    // a core only resumes while the package sits at the high operating point
    assert_resume_when_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != C_RUN) ##1 (state_q == C_RUN) |-> $past(pkg_allow));

    // a handler return with nothing outstanding leaves a running core alone
    assert_stray_return_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_RUN && smi_done && !smi_act_q && !halt_req) |=> (state_q == C_RUN));

endmodule

// File: rtl/pkg_idle_fsm.sv
module pkg_idle_fsm
    import idle_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    all_halt,
    input  logic    none_run,
    input  logic    wake_any,
    input  logic    deep_en,
    input  logic    ratio_ack,
    input  logic    vid_ack,
    output pkg_st_e state_o,
    output logic    ratio_low_req,
    output logic    vid_low_req,
    output logic    allow_o
);

    pkg_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_NORMAL, P_HALT: begin
                if (all_halt && deep_en && !wake_any)
                    state_d = P_ENTER_RATIO;
                else if (none_run)
                    state_d = P_HALT;
                else
                    state_d = P_NORMAL;
            end
            P_ENTER_RATIO: begin
                if (wake_any)
                    state_d = P_EXIT_RATIO;
                else if (ratio_ack)
                    state_d = P_ENTER_VID;
            end
            P_ENTER_VID: begin
                if (wake_any)
                    state_d = P_EXIT_VID;
                else if (vid_ack)
                    state_d = P_EXT_HALT;
            end
            P_EXT_HALT: begin
                if (wake_any)
                    state_d = P_EXIT_VID;
            end
            P_EXIT_VID: begin
                if (!vid_ack)
                    state_d = P_EXIT_RATIO;
            end
            P_EXIT_RATIO: begin
                if (!ratio_ack)
                    state_d = P_HALT;
            end
            default: state_d = P_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= P_NORMAL;
        else
            state_q <= state_d;
    end

    // output decode from the state register
    always_comb begin
        ratio_low_req = 1'b0;
        vid_low_req   = 1'b0;
        allow_o       = 1'b0;
        unique case (state_q)
            P_NORMAL, P_HALT: allow_o = 1'b1;
            P_ENTER_RATIO:    ratio_low_req = 1'b1;
            P_ENTER_VID, P_EXT_HALT: begin
                ratio_low_req = 1'b1;
                vid_low_req   = 1'b1;
            end
            P_EXIT_VID:       ratio_low_req = 1'b1;
            P_EXIT_RATIO:     ratio_low_req = 1'b0;
            default:          allow_o = 1'b0;
        endcase
        state_o = state_q;
    end

    assert_vid_after_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_low_req) |-> $past(ratio_ack));

    assert_ratio_after_vid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ratio_low_req) |-> (!vid_low_req && !$past(vid_ack)));

    assert_entry_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_low_req) |-> ($past(deep_en) && $past(all_halt) && !$past(wake_any)));

endmodule

// File: rtl/snoop_gate.sv
module snoop_gate
    import idle_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    snoop_req,
    input  pkg_st_e pkg_state,
    output logic    snoop_gnt
);

    logic settled;

    always_comb begin
        settled = (pkg_state == P_NORMAL) || (pkg_state == P_HALT) || (pkg_state == P_EXT_HALT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snoop_gnt <= 1'b0;
        else
            snoop_gnt <= snoop_req && settled;
    end

    assert_gnt_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_gnt |-> $past(snoop_req));

endmodule

// File: rtl/dual_core_idle_ctrl.sv
module dual_core_idle_ctrl
    import idle_ctrl_pkg::*;
#(
    parameter int NCORES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCORES-1:0]             halt_req,
    input  logic                          deep_en,
    input  logic [NCORES-1:0]             smi_evt,
    input  logic [NCORES-1:0]             binit_evt,
    input  logic [NCORES-1:0]             init_evt,
    input  logic [NCORES-1:0]             nmi_evt,
    input  logic [NCORES-1:0]             intr_evt,
    input  logic [NCORES-1:0]             bus_int_evt,
    input  logic [NCORES-1:0]             smi_done,
    input  logic [NCORES-1:0]             smi_ret_halt,
    input  logic                          stop_clk_req,
    input  logic                          snoop_req,
    input  logic                          ratio_ack,
    input  logic                          vid_ack,
    output logic [NCORES-1:0]             core_running,
    output logic [CORE_ST_W*NCORES-1:0]   core_state,
    output logic [PKG_ST_W-1:0]           pkg_state,
    output logic                          ratio_low_req,
    output logic                          vid_low_req,
    output logic                          snoop_gnt
);

    core_st_e          cst [NCORES];
    logic [NCORES-1:0] pend;
    logic [NCORES-1:0] run_v;
    logic [NCORES-1:0] halt_v;
    logic [NCORES-1:0] wake_v;
    pkg_st_e           pst;
    logic              allow;

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        assign wake_v[g] = smi_evt[g] | binit_evt[g] | init_evt[g]
                         | nmi_evt[g] | intr_evt[g] | bus_int_evt[g];

        core_idle_fsm u_core (
            .clk          (clk),
            .rst_n        (rst_n),
            .halt_req     (halt_req[g]),
            .wake_evt     (wake_v[g]),
            .smi_evt      (smi_evt[g]),
            .smi_done     (smi_done[g]),
            .smi_ret_halt (smi_ret_halt[g]),
            .stop_clk_req (stop_clk_req),
            .pkg_allow    (allow),
            .state_o      (cst[g]),
            .wake_pend_o  (pend[g])
        );

        assign run_v[g]  = (cst[g] == C_RUN);
        assign halt_v[g] = (cst[g] == C_HALT);
        assign core_state[CORE_ST_W*g +: CORE_ST_W] = cst[g];
    end

    pkg_idle_fsm u_pkg (
        .clk           (clk),
        .rst_n         (rst_n),
        .all_halt      (&halt_v),
        .none_run      (~|run_v),
        .wake_any      (|pend),
        .deep_en       (deep_en),
        .ratio_ack     (ratio_ack),
        .vid_ack       (vid_ack),
        .state_o       (pst),
        .ratio_low_req (ratio_low_req),
        .vid_low_req   (vid_low_req),
        .allow_o       (allow)
    );

    snoop_gate u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .snoop_req (snoop_req),
        .pkg_state (pst),
        .snoop_gnt (snoop_gnt)
    );

    assign core_running = run_v;
    assign pkg_state    = pst;

    // no core executes while the package is away from its settled high point
    assert_no_run_off_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |-> (run_v == '0));

endmodule

// File: tb/dual_core_idle_ctrl_test.sv
module dual_core_idle_ctrl_test;

    localparam int N = 2;

    localparam logic [2:0] S_NORMAL = 3'd0, S_HALT = 3'd1, S_ENTER_RATIO = 3'd2,
                           S_ENTER_VID = 3'd3, S_EXT_HALT = 3'd4, S_EXIT_VID = 3'd5,
                           S_EXIT_RATIO = 3'd6;
    localparam logic [1:0] K_RUN = 2'd0, K_HALT = 2'd1, K_SG = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] halt_req = '0, smi_evt = '0, binit_evt = '0, init_evt = '0;
    logic [N-1:0] nmi_evt = '0, intr_evt = '0, bus_int_evt = '0;
    logic [N-1:0] smi_done = '0, smi_ret_halt = '0;
    logic deep_en = 1'b0, stop_clk_req = 1'b0, snoop_req = 1'b0;
    logic ratio_ack, vid_ack;
    logic [N-1:0] core_running;
    logic [2*N-1:0] core_state;
    logic [2:0] pkg_state;
    logic ratio_low_req, vid_low_req, snoop_gnt;

    // acknowledge model: automatic follower or manual levels
    logic ack_auto = 1'b1;
    logic ratio_man = 1'b0, vid_man = 1'b0;
    logic ratio_q, vid_q;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= 1'b0;
            vid_q   <= 1'b0;
        end else begin
            ratio_q <= ratio_low_req;
            vid_q   <= vid_low_req;
        end
    end

    assign ratio_ack = ack_auto ? ratio_q : ratio_man;
    assign vid_ack   = ack_auto ? vid_q   : vid_man;

    dual_core_idle_ctrl #(.NCORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .deep_en(deep_en),
        .smi_evt(smi_evt), .binit_evt(binit_evt), .init_evt(init_evt),
        .nmi_evt(nmi_evt), .intr_evt(intr_evt), .bus_int_evt(bus_int_evt),
        .smi_done(smi_done), .smi_ret_halt(smi_ret_halt),
        .stop_clk_req(stop_clk_req), .snoop_req(snoop_req),
        .ratio_ack(ratio_ack), .vid_ack(vid_ack),
        .core_running(core_running), .core_state(core_state),
        .pkg_state(pkg_state), .ratio_low_req(ratio_low_req),
        .vid_low_req(vid_low_req), .snoop_gnt(snoop_gnt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cs(input int i);
        return int'(core_state[2*i +: 2]);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pkg(input logic [2:0] st, input string req);
        int k = 0;
        while (pkg_state != st && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(req, "package reaches state", int'(pkg_state), int'(st));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ack_auto = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic pulse_halt(input int c);
        halt_req[c] = 1'b1;
        tick(1);
        halt_req = '0;
    endtask

    task automatic pulse_wake(input int c, input int src);
        case (src)
            0: smi_evt[c] = 1'b1;
            1: binit_evt[c] = 1'b1;
            2: init_evt[c] = 1'b1;
            3: nmi_evt[c] = 1'b1;
            4: intr_evt[c] = 1'b1;
            default: bus_int_evt[c] = 1'b1;
        endcase
        tick(1);
        smi_evt = '0; binit_evt = '0; init_evt = '0;
        nmi_evt = '0; intr_evt = '0; bus_int_evt = '0;
    endtask

    task automatic snoop_probe(input int exp, input string req);
        snoop_req = 1'b1;
        tick(1);
        snoop_req = 1'b0;
        chk(req, "snoop grant", int'(snoop_gnt), exp);
    endtask

    // R3 and R12: values straight out of reset
    task automatic t_reset_state();
        do_reset();
        chk("R3", "package after reset", int'(pkg_state), S_NORMAL);
        chk("R3", "core0 after reset", cs(0), K_RUN);
        chk("R3", "core1 after reset", cs(1), K_RUN);
        chk("R12", "running flags after reset", int'(core_running), 3);
        chk("R3", "ratio request after reset", int'(ratio_low_req), 0);
        chk("R3", "vid request after reset", int'(vid_low_req), 0);
        chk("R3", "snoop grant after reset", int'(snoop_gnt), 0);
    endtask

    // R1, R2: one core halts, every wake source brings it back
    task automatic t_single_halt();
        deep_en = 1'b0;
        for (int src = 0; src < 6; src++) begin
            pulse_halt(0);
            chk("R1", "halted core", cs(0), K_HALT);
            chk("R1", "other core keeps running", cs(1), K_RUN);
            chk("R12", "running flag of halted core", int'(core_running[0]), 0);
            pulse_wake(0, src);
            tick(1);
            chk("R2", $sformatf("woken by source %0d", src), cs(0), K_RUN);
        end
        // halt together with a wake in the same cycle is not taken
        halt_req[1] = 1'b1;
        intr_evt[1] = 1'b1;
        tick(1);
        halt_req = '0;
        intr_evt = '0;
        chk("R1", "halt with coincident wake ignored", cs(1), K_RUN);
    endtask

    // R6, R7, R4: package halt without enhanced entry, then stop-grant
    task automatic t_pkg_halt();
        deep_en = 1'b0;
        pulse_halt(0);
        pulse_halt(1);
        wait_pkg(S_HALT, "R6");
        tick(5);
        chk("R7", "disabled entry keeps package in HALT", int'(pkg_state), S_HALT);
        chk("R7", "no ratio request when disabled", int'(ratio_low_req), 0);
        stop_clk_req = 1'b1;
        tick(1);
        chk("R4", "stop-clock in halt", cs(0), K_SG);
        chk("R4", "stop-clock in halt core1", cs(1), K_SG);
        stop_clk_req = 1'b0;
        tick(1);
        chk("R4", "return to halt, not run", cs(0), K_HALT);
        tick(2);
        chk("R4", "still halted later", cs(0), K_HALT);
        snoop_probe(1, "R5");
        pulse_wake(1, 5);
        tick(1);
        chk("R2", "core1 resumes", cs(1), K_RUN);
        wait_pkg(S_NORMAL, "R6");
    endtask

    // R8, R9, R5: full entry and exit with following acknowledges
    task automatic t_enter_exit();
        deep_en = 1'b1;
        ack_auto = 1'b1;
        pulse_halt(1);
        wait_pkg(S_ENTER_RATIO, "R7");
        chk("R8", "ratio requested first", int'(ratio_low_req), 1);
        chk("R8", "vid held during ratio step", int'(vid_low_req), 0);
        wait_pkg(S_ENTER_VID, "R8");
        chk("R8", "vid requested after ratio ack", int'(vid_low_req), 1);
        wait_pkg(S_EXT_HALT, "R8");
        chk("R8", "ratio low in ext halt", int'(ratio_low_req), 1);
        snoop_probe(1, "R5");
        pulse_wake(1, 4);
        wait_pkg(S_EXIT_VID, "R9");
        chk("R9", "vid restored first", int'(vid_low_req), 0);
        chk("R9", "ratio still low while vid restores", int'(ratio_low_req), 1);
        chk("R9", "woken core waits in exit", cs(1), K_HALT);
        wait_pkg(S_EXIT_RATIO, "R9");
        chk("R9", "ratio restored second", int'(ratio_low_req), 0);
        chk("R9", "woken core still waits", cs(1), K_HALT);
        wait_pkg(S_HALT, "R9");
        tick(1);
        chk("R9", "woken core runs after exit", cs(1), K_RUN);
        chk("R9", "other core stays halted", cs(0), K_HALT);
        wait_pkg(S_NORMAL, "R9");
    endtask

    // R10, R5: abort in each entry step with manual acknowledges
    task automatic t_abort();
        ack_auto = 1'b0;
        ratio_man = 1'b0;
        vid_man = 1'b0;
        deep_en = 1'b1;
        pulse_halt(1);
        wait_pkg(S_ENTER_RATIO, "R7");
        pulse_wake(0, 3);
        tick(1);
        chk("R10", "abort from ratio step", int'(pkg_state), S_EXIT_RATIO);
        chk("R10", "ratio request withdrawn", int'(ratio_low_req), 0);
        wait_pkg(S_HALT, "R10");
        tick(1);
        chk("R10", "woken core runs after abort", cs(0), K_RUN);
        wait_pkg(S_NORMAL, "R10");
        pulse_halt(0);
        wait_pkg(S_ENTER_RATIO, "R7");
        ratio_man = 1'b1;
        wait_pkg(S_ENTER_VID, "R8");
        tick(3);
        chk("R8", "no ext halt without vid ack", int'(pkg_state), S_ENTER_VID);
        snoop_probe(0, "R5");
        pulse_wake(1, 1);
        tick(1);
        chk("R10", "abort from vid step", int'(pkg_state), S_EXIT_VID);
        chk("R10", "ratio kept during vid unwind", int'(ratio_low_req), 1);
        wait_pkg(S_EXIT_RATIO, "R10");
        tick(3);
        chk("R10", "waits for ratio ack low", int'(pkg_state), S_EXIT_RATIO);
        ratio_man = 1'b0;
        wait_pkg(S_HALT, "R10");
        tick(1);
        chk("R10", "woken core runs after vid abort", cs(1), K_RUN);
        wait_pkg(S_NORMAL, "R10");
        ack_auto = 1'b1;
        deep_en = 1'b0;
    endtask

    // R11: return from management handler
    task automatic t_smi();
        do_reset();
        smi_ret_halt[0] = 1'b1;
        smi_done[0] = 1'b1;
        tick(1);
        smi_done = '0;
        chk("R11", "stray handler return ignored", cs(0), K_RUN);
        pulse_halt(0);
        pulse_wake(0, 0);
        tick(1);
        chk("R11", "smi wakes core", cs(0), K_RUN);
        smi_done[0] = 1'b1;
        tick(1);
        smi_done = '0;
        chk("R11", "return to halt", cs(0), K_HALT);
        pulse_wake(0, 0);
        tick(1);
        smi_ret_halt[0] = 1'b0;
        smi_done[0] = 1'b1;
        tick(1);
        smi_done = '0;
        tick(1);
        chk("R11", "return to normal", cs(0), K_RUN);
    endtask

    // R3: reset in the middle of the low-voltage state
    task automatic t_reset_mid();
        deep_en = 1'b1;
        pulse_halt(0);
        pulse_halt(1);
        wait_pkg(S_EXT_HALT, "R8");
        #5;
        rst_n = 1'b0;
        #1;
        chk("R3", "async reset package", int'(pkg_state), S_NORMAL);
        chk("R3", "async reset ratio", int'(ratio_low_req), 0);
        chk("R3", "async reset vid", int'(vid_low_req), 0);
        chk("R3", "async reset cores", int'(core_state), 0);
        deep_en = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        t_reset_state();
        t_single_halt();
        t_pkg_halt();
        t_enter_exit();
        t_abort();
        t_smi();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule